// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Tracker

This block keeps the single address reservation of a core's atomic load-reserved / store-conditional pair and decides whether each store-conditional may write memory. When a load-reserved finishes its read without an exception, the core reports the translated physical address on the set port. The block keeps a valid bit and the address tag of the 8-byte granule that holds it. An invalidate input, driven by snoop hits from other agents, drops the reservation.

A store-conditional arrives on a valid/ready request. The request carries the virtual address, the access size, the translation outcome and, when translation succeeded, the physical address. The controller checks the checks in a fixed order: alignment first, then the translation fault, then the reservation compare on the physical address. On a match it issues one memory write and waits for that write to complete. Each request produces exactly one response. The response carries the destination register value, an exception flag and a cause. The reservation is not tied to privilege changes: traps, returns from handlers and wait-for-interrupt have no port here, so they cannot disturb it.

The controller is a four-state machine. IDLE accepts a request (IDLE→CHECK on `sc_valid_i`). CHECK takes one of three paths: it goes to RESP on a fault or on a mismatch (CHECK→RESP), or to WRITE on a match (CHECK→WRITE). WRITE holds the write request until it completes (WRITE→RESP on `wr_done_i`). RESP holds the response until it is taken (RESP→IDLE on `rsp_ready_i`).

Top module: `lrsc_resv_unit`

## Requirements
- R1: After reset no reservation is held, `sc_ready_o` is 1, and `rsp_valid_o` and `wr_req_o` are 0. A store-conditional issued before any load-reserved therefore fails with value 1.
- R2: A set event records the physical address at 8-byte granule resolution. A later store-conditional whose physical address lies in the same granule (address bits above bit 2 equal) matches.
- R3: A new set event replaces any earlier reservation, so only the latest granule matches.
- R4: An invalidate with no set event in the same cycle clears the reservation. When a set event and an invalidate arrive in the same cycle, the set wins and the reservation is valid.
- R5: Size code n (0=1, 1=2, 2=4, 3=8 bytes) requires virtual address bits [n-1:0] to be zero. A misaligned store-conditional responds with exception cause 6 and value 0. It issues no write and leaves the reservation unchanged.
- R6: An aligned request with a translation fault responds with an exception carrying the supplied cause and value 0. It issues no write and leaves the reservation unchanged.
- R7: An aligned, translated request that does not match responds with value 1 and no exception. It issues no write and clears the reservation.
- R8: A matching request issues exactly one write to its physical address and clears the reservation. When the write completes without fault, the response has value 0 and no exception.
- R9: When the write of a matching request faults, the response carries exception cause 7 and value 0, and the reservation is still cleared.
- R10: Each accepted request yields one response. That response holds stable until `rsp_ready_i`, and `sc_ready_o` stays 0 from acceptance until the response is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lr_done_i | input | 1 | Load-reserved read completed without exception |
| lr_paddr_i | input | PA_W | Physical address of that load-reserved |
| snoop_inval_i | input | 1 | Drop the reservation |
| sc_valid_i | input | 1 | Store-conditional request valid |
| sc_ready_o | output | 1 | Request accepted when high |
| sc_vaddr_i | input | XLEN | Virtual address |
| sc_size_i | input | 2 | Size code |
| sc_xlat_fault_i | input | 1 | Translation faulted |
| sc_xlat_cause_i | input | CAUSE_W | Cause for a translation fault |
| sc_paddr_i | input | PA_W | Translated physical address |
| wr_req_o | output | 1 | Memory write request |
| wr_addr_o | output | PA_W | Write physical address |
| wr_done_i | input | 1 | Write completed |
| wr_fault_i | input | 1 | Write faulted |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response taken |
| rsp_rd_o | output | XLEN | Destination register value |
| rsp_exc_o | output | 1 | Exception raised |
| rsp_cause_o | output | CAUSE_W | Exception cause, 0 when none |

## Verification
Two effects are hard to observe from the ports. A fault that must leave the reservation alone, and a simultaneous set and invalidate, both change nothing visible at the moment they happen. The bench therefore follows every swept store-conditional with a probe store-conditional to the reserved granule, and the probe's pass or fail reveals whether the reservation survived. The sweep covers every size code against every offset inside a granule, each with no fault, a translation fault and a write fault.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_CHECK = 2'd1,
        S_WRITE = 2'd2,
        S_RESP  = 2'd3
    } sc_state_t;

    localparam int CAUSE_SAMO_MISALIGN = 6;
    localparam int CAUSE_SAMO_ACCESS   = 7;
endpackage

// File: rtl/resv_store.sv
module resv_store #(
    parameter int PA_W    = 56,
    parameter int GRAN_LG = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_i,
    input  logic [PA_W-1:0] set_addr_i,
    input  logic            clr_i,
    input  logic [PA_W-1:0] cmp_addr_i,
    output logic            match_o
);
    localparam int TAG_W = PA_W - GRAN_LG;

    logic             valid_q;
    logic [TAG_W-1:0] tag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            tag_q   <= '0;
        end else if (set_i) begin
            valid_q <= 1'b1;
            tag_q   <= set_addr_i[PA_W-1:GRAN_LG];
        end else if (clr_i) begin
            valid_q <= 1'b0;
        end
    end

    assign match_o = valid_q && (tag_q == cmp_addr_i[PA_W-1:GRAN_LG]);

    // R4
    resv_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> valid_q);
    // R4
    resv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !valid_q);
    // R6
    resv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !set_i) |=> ($stable(valid_q) && $stable(tag_q)));
endmodule

// File: rtl/sc_align_chk.sv
module sc_align_chk #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] vaddr_i,
    input  logic [1:0]      size_i,
    output logic            misal_o
);
    localparam int LOW_BITS = 3;

    logic [LOW_BITS-1:0] bad;

    for (genvar k = 0; k < LOW_BITS; k++) begin : g_bit
        assign bad[k] = vaddr_i[k] && (int'(size_i) > k);
    end

    assign misal_o = |bad;
endmodule

// File: rtl/sc_ctrl.sv
module sc_ctrl
    import lrsc_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int PA_W    = 56,
    parameter int CAUSE_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sc_valid_i,
    output logic               sc_ready_o,
    input  logic               misal_i,
    input  logic               xlat_fault_i,
    input  logic [CAUSE_W-1:0] xlat_cause_i,
    input  logic [PA_W-1:0]    paddr_i,
    output logic [PA_W-1:0]    cmp_addr_o,
    input  logic               match_i,
    output logic               resv_clr_o,
    output logic               wr_req_o,
    output logic [PA_W-1:0]    wr_addr_o,
    input  logic               wr_done_i,
    input  logic               wr_fault_i,
    output logic               rsp_valid_o,
    input  logic               rsp_ready_i,
    output logic [XLEN-1:0]    rsp_rd_o,
    output logic               rsp_exc_o,
    output logic [CAUSE_W-1:0] rsp_cause_o
);
    sc_state_t st_q, st_d;

    logic               misal_q, fault_q;
    logic [CAUSE_W-1:0] xcause_q;
    logic [PA_W-1:0]    paddr_q;
    logic               rd_one_q, exc_q;
    logic [CAUSE_W-1:0] cause_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE:  if (sc_valid_i) st_d = S_CHECK;
            S_CHECK: begin
                if (misal_q || fault_q) st_d = S_RESP;
                else if (match_i)       st_d = S_WRITE;
                else                    st_d = S_RESP;
            end
            S_WRITE: if (wr_done_i)   st_d = S_RESP;
            S_RESP:  if (rsp_ready_i) st_d = S_IDLE;
            default: st_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            misal_q  <= 1'b0;
            fault_q  <= 1'b0;
            xcause_q <= '0;
            paddr_q  <= '0;
            rd_one_q <= 1'b0;
            exc_q    <= 1'b0;
            cause_q  <= '0;
        end else begin
            unique case (st_q)
                S_IDLE: if (sc_valid_i) begin
                    misal_q  <= misal_i;
                    fault_q  <= xlat_fault_i;
                    xcause_q <= xlat_cause_i;
                    paddr_q  <= paddr_i;
                end
                S_CHECK: begin
                    if (misal_q) begin
                        rd_one_q <= 1'b0;
                        exc_q    <= 1'b1;
                        cause_q  <= CAUSE_W'(CAUSE_SAMO_MISALIGN);
                    end else if (fault_q) begin
                        rd_one_q <= 1'b0;
                        exc_q    <= 1'b1;
                        cause_q  <= xcause_q;
                    end else if (!match_i) begin
                        rd_one_q <= 1'b1;
                        exc_q    <= 1'b0;
                        cause_q  <= '0;
                    end
                end
                S_WRITE: if (wr_done_i) begin
                    rd_one_q <= 1'b0;
                    exc_q    <= wr_fault_i;
                    cause_q  <= wr_fault_i ? CAUSE_W'(CAUSE_SAMO_ACCESS) : '0;
                end
                S_RESP: ;
                default: ;
            endcase
        end
    end

    assign sc_ready_o  = (st_q == S_IDLE);
    assign wr_req_o    = (st_q == S_WRITE);
    assign rsp_valid_o = (st_q == S_RESP);
    assign resv_clr_o  = (st_q == S_CHECK) && !misal_q && !fault_q;
    assign cmp_addr_o  = paddr_q;
    assign wr_addr_o   = paddr_q;
    assign rsp_rd_o    = XLEN'(rd_one_q);
    assign rsp_exc_o   = exc_q;
    assign rsp_cause_o = cause_q;

    // R10
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && !rsp_ready_i) |=>
            (rsp_valid_o && $stable(rsp_rd_o) && $stable(rsp_exc_o) && $stable(rsp_cause_o)));
    // R10
    busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sc_ready_o |-> (!rsp_valid_o && !wr_req_o));
    // R8
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_o && !wr_done_i) |=> (wr_req_o && $stable(wr_addr_o)));
    // R5
    exc_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && rsp_exc_o) |-> (rsp_rd_o == '0));
    // R7
    ok_no_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && !rsp_exc_o) |-> (rsp_cause_o == '0));
endmodule

// File: rtl/lrsc_resv_unit.sv
module lrsc_resv_unit #(
    parameter int XLEN    = 64,
    parameter int PA_W    = 56,
    parameter int GRAN_LG = 3,
    parameter int CAUSE_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lr_done_i,
    input  logic [PA_W-1:0]    lr_paddr_i,
    input  logic               snoop_inval_i,
    input  logic               sc_valid_i,
    output logic               sc_ready_o,
    input  logic [XLEN-1:0]    sc_vaddr_i,
    input  logic [1:0]         sc_size_i,
    input  logic               sc_xlat_fault_i,
    input  logic [CAUSE_W-1:0] sc_xlat_cause_i,
    input  logic [PA_W-1:0]    sc_paddr_i,
    output logic               wr_req_o,
    output logic [PA_W-1:0]    wr_addr_o,
    input  logic               wr_done_i,
    input  logic               wr_fault_i,
    output logic               rsp_valid_o,
    input  logic               rsp_ready_i,
    output logic [XLEN-1:0]    rsp_rd_o,
    output logic               rsp_exc_o,
    output logic [CAUSE_W-1:0] rsp_cause_o
);
    logic            misal;
    logic            match;
    logic            sc_clr;
    logic [PA_W-1:0] cmp_addr;

    sc_align_chk #(.XLEN(XLEN)) u_align (
        .vaddr_i (sc_vaddr_i),
        .size_i  (sc_size_i),
        .misal_o (misal)
    );

    resv_store #(.PA_W(PA_W), .GRAN_LG(GRAN_LG)) u_resv (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (lr_done_i),
        .set_addr_i (lr_paddr_i),
        .clr_i      (snoop_inval_i || sc_clr),
        .cmp_addr_i (cmp_addr),
        .match_o    (match)
    );

    sc_ctrl #(.XLEN(XLEN), .PA_W(PA_W), .CAUSE_W(CAUSE_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .sc_valid_i   (sc_valid_i),
        .sc_ready_o   (sc_ready_o),
        .misal_i      (misal),
        .xlat_fault_i (sc_xlat_fault_i),
        .xlat_cause_i (sc_xlat_cause_i),
        .paddr_i      (sc_paddr_i),
        .cmp_addr_o   (cmp_addr),
        .match_i      (match),
        .resv_clr_o   (sc_clr),
        .wr_req_o     (wr_req_o),
        .wr_addr_o    (wr_addr_o),
        .wr_done_i    (wr_done_i),
        .wr_fault_i   (wr_fault_i),
        .rsp_valid_o  (rsp_valid_o),
        .rsp_ready_i  (rsp_ready_i),
        .rsp_rd_o     (rsp_rd_o),
        .rsp_exc_o    (rsp_exc_o),
        .rsp_cause_o  (rsp_cause_o)
    );
endmodule

// File: tb/lrsc_resv_unit_test.sv
module lrsc_resv_unit_test;
    localparam int XLEN = 64;
    localparam int PA_W = 56;
    localparam int CW   = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            lr_done_i = 1'b0;
    logic [PA_W-1:0] lr_paddr_i = '0;
    logic            snoop_inval_i = 1'b0;
    logic            sc_valid_i = 1'b0;
    logic            sc_ready_o;
    logic [XLEN-1:0] sc_vaddr_i = '0;
    logic [1:0]      sc_size_i = '0;
    logic            sc_xlat_fault_i = 1'b0;
    logic [CW-1:0]   sc_xlat_cause_i = '0;
    logic [PA_W-1:0] sc_paddr_i = '0;
    logic            wr_req_o;
    logic [PA_W-1:0] wr_addr_o;
    logic            wr_done_i = 1'b0;
    logic            wr_fault_i = 1'b0;
    logic            rsp_valid_o;
    logic            rsp_ready_i = 1'b0;
    logic [XLEN-1:0] rsp_rd_o;
    logic            rsp_exc_o;
    logic [CW-1:0]   rsp_cause_o;

    lrsc_resv_unit uut (.*);

    always #4 clk = ~clk;

    int n_run = 0, n_fail = 0, cyc = 0;
    int wr_cnt = 0;
    logic [PA_W-1:0] wr_seen = '0;
    logic tb_wr_fault = 1'b0;
    logic            m_valid = 1'b0;
    logic [PA_W-1:0] m_addr = '0;
    logic [XLEN-1:0] g_rd;
    logic            g_exc;
    logic [CW-1:0]   g_cause;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog: act=%0d cycles exp=finish", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    // write responder: completes a write one cycle after request
    always @(negedge clk) begin
        if (wr_req_o && !wr_done_i) begin
            wr_done_i  = 1'b1;
            wr_fault_i = tb_wr_fault;
            wr_cnt++;
            wr_seen = wr_addr_o;
        end else begin
            wr_done_i  = 1'b0;
            wr_fault_i = 1'b0;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic do_lr(input logic [PA_W-1:0] a, input logic inval);
        @(negedge clk);
        lr_done_i = 1'b1; lr_paddr_i = a; snoop_inval_i = inval;
        @(negedge clk);
        lr_done_i = 1'b0; snoop_inval_i = 1'b0;
        m_valid = 1'b1; m_addr = a;
    endtask

    task automatic do_inval();
        @(negedge clk);
        snoop_inval_i = 1'b1;
        @(negedge clk);
        snoop_inval_i = 1'b0;
        m_valid = 1'b0;
    endtask

    task automatic do_sc(input string ctx, input logic [XLEN-1:0] va, input logic [1:0] sz,
                         input logic xf, input logic [CW-1:0] xc,
                         input logic [PA_W-1:0] pa, input logic wf, input int hold);
        int w0;
        logic mis, hit;
        logic [XLEN-1:0] e_rd;
        logic e_exc;
        logic [CW-1:0] e_cause;
        int e_wr;
        string tag;
        mis = (va & ((64'd1 << sz) - 64'd1)) != 0;
        hit = m_valid && (m_addr[PA_W-1:3] == pa[PA_W-1:3]);
        e_wr = 0;
        if (mis) begin
            tag = "R5"; e_rd = 0; e_exc = 1; e_cause = 6;
        end else if (xf) begin
            tag = "R6"; e_rd = 0; e_exc = 1; e_cause = xc;
        end else if (hit) begin
            e_wr = 1; e_rd = 0; m_valid = 1'b0;
            if (wf) begin tag = "R9"; e_exc = 1; e_cause = 7; end
            else begin tag = "R8"; e_exc = 0; e_cause = 0; end
        end else begin
            tag = "R7"; e_rd = 1; e_exc = 0; e_cause = 0; m_valid = 1'b0;
        end
        w0 = wr_cnt;
        tb_wr_fault = wf;
        @(negedge clk);
        sc_valid_i = 1'b1; sc_vaddr_i = va; sc_size_i = sz;
        sc_xlat_fault_i = xf; sc_xlat_cause_i = xc; sc_paddr_i = pa;
        @(negedge clk);
        sc_valid_i = 1'b0;
        for (int i = 0; i < 20 && !rsp_valid_o; i++) @(negedge clk);
        g_rd = rsp_rd_o; g_exc = rsp_exc_o; g_cause = rsp_cause_o;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            // R10: response held, no new acceptance
            chk({ctx, "/R10 hold"}, {62'd0, rsp_valid_o, sc_ready_o}, 64'd2);
            chk({ctx, "/R10 stable"}, rsp_rd_o, g_rd);
        end
        chk({ctx, "/", tag, " valid"}, {63'd0, rsp_valid_o}, 64'd1);
        chk({ctx, "/", tag, " rd"}, g_rd, e_rd);
        chk({ctx, "/", tag, " exc"}, {63'd0, g_exc}, {63'd0, e_exc});
        chk({ctx, "/", tag, " cause"}, {59'd0, g_cause}, {59'd0, e_cause});
        rsp_ready_i = 1'b1;
        @(negedge clk);
        rsp_ready_i = 1'b0;
        chk({ctx, "/", tag, " writes"}, 64'(wr_cnt - w0), 64'(e_wr));
        if (e_wr == 1) chk({ctx, "/R8 waddr"}, {8'd0, wr_seen}, {8'd0, pa});
        chk({ctx, "/R10 ready"}, {63'd0, sc_ready_o}, 64'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 ready", {63'd0, sc_ready_o}, 64'd1);
        chk("R1 rsp", {63'd0, rsp_valid_o}, 64'd0);
        chk("R1 wr", {63'd0, wr_req_o}, 64'd0);
        rst_n = 1'b1;
        do_sc("R1 empty", 64'h100, 2'd3, 1'b0, 5'd0, 56'h1000, 1'b0, 0);

        // sweep size x offset x fault kind, then probe the reservation
        for (int s = 0; s < 4; s++)
            for (int o = 0; o < 8; o++)
                for (int f = 0; f < 3; f++) begin
                    do_lr(56'h4000, 1'b0);
                    do_sc("sweep", 64'h9000 + 64'(o), 2'(s), f == 1, 5'd13,
                          56'h4000 + 56'(o), f == 2, 0);
                    do_sc("probe", 64'h9000, 2'd3, 1'b0, 5'd0, 56'h4000, 1'b0, 0);
                end

        // R2: granule match
        do_lr(56'h2007, 1'b0);
        do_sc("R2 granule", 64'h50, 2'd3, 1'b0, 5'd0, 56'h2000, 1'b0, 0);
        do_lr(56'h2007, 1'b0);
        do_sc("R2 other", 64'h50, 2'd3, 1'b0, 5'd0, 56'h2008, 1'b0, 0);

        // R3: replacement
        do_lr(56'h3000, 1'b0);
        do_lr(56'h3100, 1'b0);
        do_sc("R3 old", 64'h60, 2'd2, 1'b0, 5'd0, 56'h3000, 1'b0, 0);
        do_lr(56'h3000, 1'b0);
        do_lr(56'h3100, 1'b0);
        do_sc("R3 new", 64'h60, 2'd2, 1'b0, 5'd0, 56'h3104, 1'b0, 0);

        // R4: invalidate, and same-cycle priority
        do_lr(56'h5000, 1'b0);
        do_inval();
        do_sc("R4 inval", 64'h70, 2'd3, 1'b0, 5'd0, 56'h5000, 1'b0, 0);
        do_lr(56'h5000, 1'b1);
        do_sc("R4 tie", 64'h70, 2'd3, 1'b0, 5'd0, 56'h5000, 1'b0, 0);

        // R10: delayed response take
        do_lr(56'h6000, 1'b0);
        do_sc("R10 delay", 64'h80, 2'd1, 1'b0, 5'd0, 56'h6002, 1'b0, 4);
        do_sc("R10 delay2", 64'h80, 2'd1, 1'b0, 5'd0, 56'h6002, 1'b0, 3);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule